// File: doc/BRIEF.md
# Bit-Serial Accumulating Adder

This block sums two `WIDTH`-bit words one bit position per clock, using one full-adder cell that is reused for every position. An accumulator shift register holds the running total and an addend shift register holds the value to be added. A single carry flip-flop links each bit position to the next. The addition runs from the least significant bit upward. Each sum bit is shifted back into the accumulator, so a series of operations can sum any number of addends. Each operation starts from whatever the accumulator already holds.

A client loads an addend through the parallel load and, if it wants to, zeroes the accumulator. It then requests an operation. An internal bit counter keeps shifting enabled for exactly `WIDTH` clocks. During that time `busy` is high. Afterwards `done` pulses once and the accumulator holds the new sum, with the final carry dropped. The clock is never gated: when shifting is not enabled, every register simply keeps its value. The addend register rotates instead of emptying, so a second request adds the same addend again.

Top module: `serial_accum_adder`

## Requirements
- R1: While `rst` is high and on the cycle after it falls: `acc_q` reads 0, `busy` is 0, `done` is 0, and the addend register holds 0.
- R2: After an operation, `acc_q` equals (accumulator before the operation + addend) modulo 2^WIDTH. Any carry out of the top bit is discarded.
- R3: After a `start` accepted at a clock edge, `busy` is 1 for exactly `WIDTH` cycles. `done` is then 1 for exactly one cycle, with `busy` at 0.
- R4: The carry flip-flop is zeroed when an operation is accepted. A carry left over from an earlier overflowing operation therefore never enters the lowest bit of the next one.
- R5: The addend register rotates right once per shifting clock, with its least significant bit feeding the adder. After an operation it holds its value from before the operation, so repeated `start` requests accumulate the same addend.
- R6: When idle, `ld_b` copies `b_in` into the addend register. While `busy` is 1, `ld_b` is ignored.
- R7: A `start` while `busy` is 1 is ignored. The running operation ends at its original time and no further operation follows.
- R8: When idle, `clr_acc` zeroes the accumulator and the carry in one cycle and leaves the addend register untouched. While `busy` is 1, `clr_acc` is ignored.
- R9: When idle, `clr_acc`, `ld_b` and `start` can be combined in one cycle. The clear and the load take effect first, so the operation adds the newly loaded addend to zero.
- R10: While idle and with no `clr_acc`, `acc_q` holds its value on every clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_acc | input | 1 | Zero accumulator and carry (idle only) |
| ld_b | input | 1 | Parallel load of the addend (idle only) |
| b_in | input | WIDTH | Addend value for `ld_b` |
| start | input | 1 | Request one serial addition (idle only) |
| busy | output | 1 | High while bits are being shifted |
| done | output | 1 | One-cycle pulse after the last bit |
| acc_q | output | WIDTH | Parallel read of the accumulator |

## Verification
The control inputs can meet in a single cycle in two ways. One is a clear or a load arriving together with `start` while the block is idle. The other is a `start`, load or clear arriving while an operation is already shifting. The bench provokes the first case by raising `clr_acc`, `ld_b` and `start` on one edge, and requires that the result equal the new addend alone. It provokes the second by injecting each control at a chosen bit position during an operation. It then requires that the sum, the `done` timing and the addend read back afterwards (through a clear-and-add) be unaffected. It also requires that no second operation follow the injected `start`.

// File: rtl/sar_pkg.sv
package sar_pkg;

   // Full-adder cell implementation variants.
   localparam int FA_GATES = 0;
   localparam int FA_ARITH = 1;

   // Shift register serial-input source.
   localparam int SER_EXTERNAL = 0;
   localparam int SER_ROTATE   = 1;

   typedef struct packed {
      logic sum;
      logic cout;
   } fa_out_t;

endpackage

// File: rtl/sar_full_adder.sv
module sar_full_adder
   import sar_pkg::*;
#(
   parameter int IMPL = FA_GATES
) (
   input  logic    a,
   input  logic    b,
   input  logic    cin,
   output fa_out_t res
);

   generate
      if (IMPL == FA_GATES) begin : g_gates
         logic prop;
         always_comb begin
            prop     = a ^ b;
            res.sum  = prop ^ cin;
            res.cout = (a & b) | (cin & prop);
         end
      end else if (IMPL == FA_ARITH) begin : g_arith
         logic [1:0] tot;
         always_comb begin
            tot      = {1'b0, a} + {1'b0, b} + {1'b0, cin};
            res.sum  = tot[0];
            res.cout = tot[1];
         end
      end else begin : g_bad_impl
         $error("sar_full_adder: unsupported IMPL value");
      end
   endgenerate

endmodule

// File: rtl/sar_shreg.sv
module sar_shreg
   import sar_pkg::*;
#(
   parameter int WIDTH   = 8,
   parameter int SER_SRC = SER_EXTERNAL
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clr,
   input  logic             ld,
   input  logic [WIDTH-1:0] ld_data,
   input  logic             shift,
   input  logic             ser_in,
   output logic [WIDTH-1:0] q,
   output logic             ser_out
);

   logic fill;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("sar_shreg: WIDTH must be at least 2");
      end
      if (SER_SRC == SER_ROTATE) begin : g_rot
         assign fill = q[0];
      end else if (SER_SRC == SER_EXTERNAL) begin : g_ext
         assign fill = ser_in;
      end else begin : g_bad_src
         $error("sar_shreg: unsupported SER_SRC value");
      end
   endgenerate

   assign ser_out = q[0];

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         q <= '0;
      end else if (ld) begin
         q <= ld_data;
      end else if (shift) begin
         q <= {fill, q[WIDTH-1:1]};
      end
   end

   // R5: a shifting clock moves every bit one place right and the fill enters at the top
   assert_shift_right_R5: assert property (@(posedge clk) disable iff (rst)
      (shift && !clr && !ld) |=> (q[WIDTH-2:0] == $past(q[WIDTH-1:1])))
      else $error("shift register did not shift right");

   // R10: with no control active the register holds
   assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
      (!shift && !clr && !ld) |=> $stable(q))
      else $error("shift register changed without control");

endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer #(
   parameter int WIDTH = 8
) (
   input  logic clk,
   input  logic rst,
   input  logic start_req,
   output logic busy,
   output logic done,
   output logic accept
);

   localparam int CW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
   localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

   logic [CW-1:0] bit_cnt;
   logic          at_last;

   assign accept  = start_req && !busy;
   assign at_last = (bit_cnt == LAST);

   always_ff @(posedge clk) begin
      if (rst) begin
         busy    <= 1'b0;
         done    <= 1'b0;
         bit_cnt <= '0;
      end else begin
         done <= 1'b0;
         if (accept) begin
            busy    <= 1'b1;
            bit_cnt <= '0;
         end else if (busy) begin
            if (at_last) begin
               busy    <= 1'b0;
               done    <= 1'b1;
               bit_cnt <= '0;
            end else begin
               bit_cnt <= bit_cnt + 1'b1;
            end
         end
      end
   end

   // R3: done lasts one cycle
   assert_done_pulse_R3: assert property (@(posedge clk) disable iff (rst)
      done |=> !done)
      else $error("done held for more than one cycle");

   // R3: busy falls exactly when done rises
   assert_busy_end_R3: assert property (@(posedge clk) disable iff (rst)
      $fell(busy) |-> done)
      else $error("busy dropped without done");

   // R3: done never overlaps busy
   assert_done_idle_R3: assert property (@(posedge clk) disable iff (rst)
      done |-> !busy)
      else $error("done while busy");

   // R7: a request during busy does not restart the count
   assert_no_restart_R7: assert property (@(posedge clk) disable iff (rst)
      (busy && start_req && !at_last) |=> (busy && bit_cnt != '0))
      else $error("operation restarted while busy");

endmodule

// File: rtl/serial_accum_adder.sv
module serial_accum_adder
   import sar_pkg::*;
#(
   parameter int WIDTH   = 8,
   parameter int FA_IMPL = FA_GATES
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clr_acc,
   input  logic             ld_b,
   input  logic [WIDTH-1:0] b_in,
   input  logic             start,
   output logic             busy,
   output logic             done,
   output logic [WIDTH-1:0] acc_q
);

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("serial_accum_adder: WIDTH must be at least 2");
      end
   endgenerate

   logic             accept;
   logic             clr_ok;
   logic             ld_ok;
   logic             a_bit;
   logic             b_bit;
   logic             carry_q;
   fa_out_t          fa_res;
   logic [WIDTH-1:0] b_q;

   assign clr_ok = clr_acc && !busy;
   assign ld_ok  = ld_b && !busy;

   sar_sequencer #(.WIDTH(WIDTH)) u_seq (
      .clk       (clk),
      .rst       (rst),
      .start_req (start),
      .busy      (busy),
      .done      (done),
      .accept    (accept)
   );

   sar_full_adder #(.IMPL(FA_IMPL)) u_fa (
      .a   (a_bit),
      .b   (b_bit),
      .cin (carry_q),
      .res (fa_res)
   );

   sar_shreg #(.WIDTH(WIDTH), .SER_SRC(SER_EXTERNAL)) u_acc (
      .clk     (clk),
      .rst     (rst),
      .clr     (clr_ok),
      .ld      (1'b0),
      .ld_data ('0),
      .shift   (busy),
      .ser_in  (fa_res.sum),
      .q       (acc_q),
      .ser_out (a_bit)
   );

   sar_shreg #(.WIDTH(WIDTH), .SER_SRC(SER_ROTATE)) u_addend (
      .clk     (clk),
      .rst     (rst),
      .clr     (1'b0),
      .ld      (ld_ok),
      .ld_data (b_in),
      .shift   (busy),
      .ser_in  (1'b0),
      .q       (b_q),
      .ser_out (b_bit)
   );

   always_ff @(posedge clk) begin
      if (rst || accept || clr_ok) begin
         carry_q <= 1'b0;
      end else if (busy) begin
         carry_q <= fa_res.cout;
      end
   end

   // R4: the carry starts every operation at zero
   assert_carry_cleared_R4: assert property (@(posedge clk) disable iff (rst)
      accept |=> (carry_q == 1'b0))
      else $error("carry not cleared at start");

   // R8: an idle clear zeroes the accumulator
   assert_clear_acc_R8: assert property (@(posedge clk) disable iff (rst)
      (clr_acc && !busy) |=> (acc_q == '0))
      else $error("accumulator not cleared");

   // R6: the addend is not reloaded during an operation
   assert_no_load_busy_R6: assert property (@(posedge clk) disable iff (rst)
      (busy && ld_b) |=> (b_q == {$past(b_q[0]), $past(b_q[WIDTH-1:1])}))
      else $error("addend changed by load while busy");

   // R10: idle accumulator holds without a clear
   assert_acc_idle_R10: assert property (@(posedge clk) disable iff (rst)
      (!busy && !clr_acc) |=> $stable(acc_q))
      else $error("accumulator moved while idle");

endmodule

// File: tb/test_serial_accum_adder.sv
module test_serial_accum_adder;

   localparam int W = 4;
   localparam int M = 1 << W;

   logic         clk = 1'b0;
   logic         rst;
   logic         clr_acc;
   logic         ld_b;
   logic [W-1:0] b_in;
   logic         start;
   logic         busy;
   logic         done;
   logic [W-1:0] acc_q;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   serial_accum_adder #(.WIDTH(W)) i_serial_accum_adder (
      .clk     (clk),
      .rst     (rst),
      .clr_acc (clr_acc),
      .ld_b    (ld_b),
      .b_in    (b_in),
      .start   (start),
      .busy    (busy),
      .done    (done),
      .acc_q   (acc_q)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   // Called at a negedge. Requests an operation, optionally with clear/load in
   // the same cycle, optionally injects controls at shift index inj_at.
   task automatic run_op(input logic with_clr, input logic with_ld, input logic [W-1:0] ldv,
                         input int inj_at, input logic inj_start, input logic inj_ld,
                         input logic inj_clr, input logic [W-1:0] inj_v);
      start = 1'b1; clr_acc = with_clr; ld_b = with_ld; b_in = ldv;
      @(negedge clk);
      start = 1'b0; clr_acc = 1'b0; ld_b = 1'b0;
      for (int i = 0; i < W; i++) begin
         check(busy == 1'b1 && done == 1'b0, "R3 busy window", int'(busy), 1);
         start   = inj_start && (i == inj_at);
         ld_b    = inj_ld && (i == inj_at);
         clr_acc = inj_clr && (i == inj_at);
         b_in    = inj_v;
         @(negedge clk);
      end
      start = 1'b0; ld_b = 1'b0; clr_acc = 1'b0;
      check(busy == 1'b0 && done == 1'b1, "R3 done pulse", int'(done), 1);
   endtask

   task automatic plain_op();
      run_op(1'b0, 1'b0, '0, -1, 1'b0, 1'b0, 1'b0, '0);
   endtask

   task automatic load_b(input logic [W-1:0] v);
      ld_b = 1'b1; b_in = v;
      @(negedge clk);
      ld_b = 1'b0;
   endtask

   // Clear and add: accumulator becomes the addend register contents.
   task automatic read_b(output logic [W-1:0] v);
      run_op(1'b1, 1'b0, '0, -1, 1'b0, 1'b0, 1'b0, '0);
      v = acc_q;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      summary();
   end

   initial begin
      logic [W-1:0] got;
      logic [W-1:0] held;
      rst = 1'b1; clr_acc = 1'b0; ld_b = 1'b0; b_in = '0; start = 1'b0;
      repeat (3) @(negedge clk);
      check(acc_q == '0 && busy == 1'b0 && done == 1'b0, "R1 reset outputs", int'(acc_q), 0);
      rst = 1'b0;
      @(negedge clk);
      check(acc_q == '0 && busy == 1'b0 && done == 1'b0, "R1 after reset", int'(acc_q), 0);
      read_b(got);
      check(got == '0, "R1 addend reset", int'(got), 0);

      // R2 R5 R9: exhaustive sweep
      for (int a = 0; a < M; a++) begin
         for (int b = 0; b < M; b++) begin
            run_op(1'b1, 1'b1, W'(a), -1, 1'b0, 1'b0, 1'b0, '0);
            check(acc_q == W'(a), "R9 clear+load+start", int'(acc_q), a);
            load_b(W'(b));
            plain_op();
            check(acc_q == W'((a + b) % M), "R2 sum", int'(acc_q), (a + b) % M);
            @(negedge clk);
            check(done == 1'b0, "R3 done one cycle", int'(done), 0);
            if (b == a) begin
               read_b(got);
               check(got == W'(b), "R5 addend restored", int'(got), b);
            end
         end
      end

      // R5: repeated accumulation of one addend
      load_b(W'(3));
      run_op(1'b1, 1'b0, '0, -1, 1'b0, 1'b0, 1'b0, '0);
      for (int k = 2; k <= 6; k++) begin
         plain_op();
         check(acc_q == W'((3 * k) % M), "R5 accumulate", int'(acc_q), (3 * k) % M);
      end

      // R4: overflow carry must not leak into the next operation
      run_op(1'b1, 1'b1, W'(M - 1), -1, 1'b0, 1'b0, 1'b0, '0);
      load_b(W'(1));
      plain_op();
      check(acc_q == '0, "R4 wrap", int'(acc_q), 0);
      load_b('0);
      plain_op();
      check(acc_q == '0, "R4 carry cleared", int'(acc_q), 0);

      // R10: idle hold
      run_op(1'b1, 1'b1, W'(9), -1, 1'b0, 1'b0, 1'b0, '0);
      held = acc_q;
      repeat (5) @(negedge clk);
      check(acc_q == held, "R10 idle hold", int'(acc_q), int'(held));

      // R8: idle clear keeps addend
      load_b(W'(6));
      clr_acc = 1'b1;
      @(negedge clk);
      clr_acc = 1'b0;
      check(acc_q == '0, "R8 idle clear", int'(acc_q), 0);
      plain_op();
      check(acc_q == W'(6), "R8 addend untouched", int'(acc_q), 6);

      // Injections during busy at each bit position
      for (int p = 0; p < W; p++) begin
         // R7: start while busy
         run_op(1'b1, 1'b1, W'(5), -1, 1'b0, 1'b0, 1'b0, '0);
         run_op(1'b0, 1'b0, '0, p, 1'b1, 1'b0, 1'b0, '0);
         check(acc_q == W'(10), "R7 result", int'(acc_q), 10);
         for (int i = 0; i < W + 2; i++) begin
            @(negedge clk);
            check(busy == 1'b0 && done == 1'b0, "R7 no extra op", int'(busy), 0);
         end
         // R6: load while busy
         run_op(1'b0, 1'b0, '0, p, 1'b0, 1'b1, 1'b0, W'(12));
         check(acc_q == W'(15), "R6 result", int'(acc_q), 15);
         read_b(got);
         check(got == W'(5), "R6 load ignored", int'(got), 5);
         // R8: clear while busy
         run_op(1'b0, 1'b0, '0, p, 1'b0, 1'b0, 1'b1, '0);
         check(acc_q == W'(10), "R8 clear ignored", int'(acc_q), 10);
      end

      // R6: idle load then read back
      load_b(W'(11));
      read_b(got);
      check(got == W'(11), "R6 idle load", int'(got), 11);

      summary();
   end

endmodule